// File: doc/BRIEF.md
# Ineffectual Instruction Skip Predictor

This block learns which static instructions of a program never change visible state, so that a shortened leading copy of the program can leave them out. It watches only the instructions retired by the complete, trailing copy of the program. Each retired instruction carries its PC, its kind (register write, store, branch or other), the old and new value of its destination, its register sources, its memory address and whether its branch prediction was correct. A write that leaves its destination unchanged, a write overwritten before anyone reads it, and a correctly predicted branch are each counted as no-effect evidence for that PC.

Evidence accumulates in a direct-mapped, PC-indexed table of saturating confidence counters. Pending-writer tables, one for 16 architectural registers and one for memory words, find dead writes. The fetch stage of the leading copy queries the lookup port and gets a registered skip answer one cycle later, asserted only once the counter has saturated. When the trailing copy reports that the leading copy's results mismatched, all learned state is wiped and a one-cycle recovery request is raised for the leading copy.

Top module: `isp_predictor`

## Requirements
- R1: After reset, `lk_skip` and `lead_recover` are 0 and every PC looks up as not skippable.
- R2: `lk_skip` is registered. It is 1 in the cycle after a lookup only when `lk_valid` was 1, the entry at index `lk_pc[7:2]` holds tag `lk_pc[31:8]`, and its 3-bit counter is 7. If `lk_valid` was 0, it is 0.
- R3: A retired branch (`ret_kind`=3) with `ret_br_ok`=1 adds one to its PC's counter, saturating at 7. With `ret_br_ok`=0 it sets that counter to 0.
- R4: A retired register write (`ret_kind`=1) or store (`ret_kind`=2) with `ret_old`==`ret_new` adds one to its PC's counter.
- R5: A write whose destination is still pending reports the earlier writer as dead and adds one to that writer's counter. The destination is register `ret_dst` for kind 1, or the memory word `ret_addr[31:2]` for kind 2, which uses 16 slots indexed by `ret_addr[5:2]`. A single value-changing write alone leaves counters unchanged.
- R6: A read of a pending destination sets the pending writer's counter to 0 and clears the slot. A register source is read when `ret_rs1_en`/`ret_rs2_en` is set. A memory word is read by a kind-1 retire with `ret_load`=1.
- R7: A counter rises by at most one per cycle, however many pieces of evidence name its PC in that cycle.
- R8: Evidence for a PC whose index holds another tag replaces that entry with a count of 1. A lookup of a PC whose tag differs from the stored one answers 0.
- R9: A pulse on `rs_mismatch` clears all counters and all pending writers at the same edge, and a retire in that cycle is ignored. `lk_skip` is 0 in the next cycle.
- R10: `lead_recover` is 1 exactly in the cycle after each cycle with `rs_mismatch`=1, and 0 otherwise.
- R11: A lookup and a retire of the same PC in the same cycle answer from the counter value before that retire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_valid | input | 1 | A trailing-copy instruction retires this cycle |
| ret_pc | input | 32 | PC of the retired instruction |
| ret_kind | input | 2 | 0 other, 1 register write, 2 store, 3 branch |
| ret_dst | input | 4 | Destination register of a register write |
| ret_old | input | 32 | Destination value before the write |
| ret_new | input | 32 | Destination value written |
| ret_br_ok | input | 1 | Branch outcome matched its prediction |
| ret_rs1_en | input | 1 | First register source is used |
| ret_rs1 | input | 4 | First register source |
| ret_rs2_en | input | 1 | Second register source is used |
| ret_rs2 | input | 4 | Second register source |
| ret_load | input | 1 | Register write reads memory at ret_addr |
| ret_addr | input | 32 | Byte address of a store or load |
| rs_mismatch | input | 1 | Trailing copy found a misprediction of the leading copy |
| lk_valid | input | 1 | Fetch lookup request |
| lk_pc | input | 32 | PC being fetched by the leading copy |
| lk_skip | output | 1 | Skip answer, one cycle after the lookup |
| lead_recover | output | 1 | Leading copy must restore its state |

## Verification
Retire evidence reaches the table at the edge that samples it. A lookup started on the following cycle sees the updated counter, and its answer on `lk_skip` is due one edge after that. The bench therefore drives each retire, then a lookup, and reads `lk_skip` two falling edges after the retire. The clear from `rs_mismatch` and the `lead_recover` pulse are both due at the first edge after the pulse, so both are read on the falling edge that follows it. The same-cycle case drives the retire and the lookup together and reads the answer one falling edge later.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam int XLEN      = 32;
  localparam int NREG      = 16;
  localparam int PRED_ENT  = 64;
  localparam int CONF_W    = 3;
  localparam int MEM_SLOTS = 16;
  localparam int NUPD      = 6;

  typedef enum logic [1:0] {
    KIND_OTHER  = 2'd0,
    KIND_REGWR  = 2'd1,
    KIND_STORE  = 2'd2,
    KIND_BRANCH = 2'd3
  } ret_kind_e;

  // update port slots of the confidence table
  localparam int UP_SELF    = 0;
  localparam int UP_RKILL0  = 1;
  localparam int UP_RKILL1  = 2;
  localparam int UP_RDEAD   = 3;
  localparam int UP_MKILL   = 4;
  localparam int UP_MDEAD   = 5;
endpackage

// File: rtl/isp_write_tracker.sv
module isp_write_tracker #(
  parameter int SLOTS = 16,
  parameter int KEY_W = 5,
  parameter int NRD   = 2,
  parameter int PCW   = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             rd_en   [NRD],
  input  logic [KEY_W-1:0] rd_key  [NRD],
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [PCW-1:0]   wr_pc,
  output logic             kill_v  [NRD],
  output logic [PCW-1:0]   kill_pc [NRD],
  output logic             dead_v,
  output logic [PCW-1:0]   dead_pc
);
  localparam int IDX_W = $clog2(SLOTS);
  localparam int TAG_W = KEY_W - IDX_W;

  logic             pend_q [SLOTS];
  logic [TAG_W-1:0] tag_q  [SLOTS];
  logic [PCW-1:0]   pc_q   [SLOTS];
  logic             pend_d [SLOTS];
  logic [TAG_W-1:0] tag_d  [SLOTS];
  logic [PCW-1:0]   pc_d   [SLOTS];

  logic [IDX_W-1:0] w_idx;
  logic [TAG_W-1:0] w_tag;
  assign w_idx = wr_key[IDX_W-1:0];
  assign w_tag = wr_key[KEY_W-1:IDX_W];

  // reads are resolved before the write of the same instruction
  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      pend_d[s] = pend_q[s];
      tag_d[s]  = tag_q[s];
      pc_d[s]   = pc_q[s];
    end
    dead_v  = 1'b0;
    dead_pc = '0;
    for (int r = 0; r < NRD; r++) begin
      kill_v[r]  = 1'b0;
      kill_pc[r] = '0;
      if (rd_en[r] && pend_d[rd_key[r][IDX_W-1:0]] &&
          tag_d[rd_key[r][IDX_W-1:0]] == rd_key[r][KEY_W-1:IDX_W]) begin
        kill_v[r]  = 1'b1;
        kill_pc[r] = pc_d[rd_key[r][IDX_W-1:0]];
        pend_d[rd_key[r][IDX_W-1:0]] = 1'b0;
      end
    end
    if (wr_en) begin
      if (pend_d[w_idx] && tag_d[w_idx] == w_tag) begin
        dead_v  = 1'b1;
        dead_pc = pc_d[w_idx];
      end
      pend_d[w_idx] = 1'b1;
      tag_d[w_idx]  = w_tag;
      pc_d[w_idx]   = wr_pc;
    end
    if (clear) begin
      for (int s = 0; s < SLOTS; s++) pend_d[s] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++) begin
        pend_q[s] <= 1'b0;
        tag_q[s]  <= '0;
        pc_q[s]   <= '0;
      end
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        pend_q[s] <= pend_d[s];
        tag_q[s]  <= tag_d[s];
        pc_q[s]   <= pc_d[s];
      end
    end
  end

  AST_WRITE_LEAVES_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clear) |=> pend_q[$past(w_idx)]); // R5

  AST_CLEAR_DROPS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !pend_q[0]); // R9
endmodule

// File: rtl/isp_conf_table.sv
module isp_conf_table #(
  parameter int ENTRIES = 64,
  parameter int PCW     = 30,
  parameter int CTR_W   = 3,
  parameter int NUP     = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           up_v   [NUP],
  input  logic           up_inc [NUP],
  input  logic [PCW-1:0] up_pc  [NUP],
  input  logic [PCW-1:0] lk_pc,
  output logic           lk_sat
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PCW - IDX_W;
  localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [CTR_W-1:0]   ctr_q [ENTRIES];

  logic [IDX_W-1:0] up_idx [NUP];
  logic [TAG_W-1:0] up_tag [NUP];

  for (genvar p = 0; p < NUP; p++) begin : g_port
    assign up_idx[p] = up_pc[p][IDX_W-1:0];
    assign up_tag[p] = up_pc[p][PCW-1:IDX_W];
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic             any_rst, any_inc, alloc;
    logic [TAG_W-1:0] alloc_tag;
    logic             valid_d;
    logic [TAG_W-1:0] tag_d;
    logic [CTR_W-1:0] ctr_d;

    // gather evidence of all ports aimed at this entry
    always_comb begin
      any_rst   = 1'b0;
      any_inc   = 1'b0;
      alloc     = 1'b0;
      alloc_tag = '0;
      for (int p = 0; p < NUP; p++) begin
        if (up_v[p] && up_idx[p] == IDX_W'(e)) begin
          if (valid_q[e] && tag_q[e] == up_tag[p]) begin
            if (up_inc[p]) any_inc = 1'b1;
            else           any_rst = 1'b1;
          end else if (up_inc[p] && !alloc) begin
            alloc     = 1'b1;
            alloc_tag = up_tag[p];
          end
        end
      end
    end

    always_comb begin
      valid_d = valid_q[e];
      tag_d   = tag_q[e];
      ctr_d   = ctr_q[e];
      if (clear) begin
        valid_d = 1'b0;
        ctr_d   = '0;
      end else if (any_rst) begin
        ctr_d = '0;
      end else if (any_inc) begin
        if (ctr_q[e] != CTR_MAX) ctr_d = ctr_q[e] + 1'b1;
      end else if (alloc) begin
        valid_d = 1'b1;
        tag_d   = alloc_tag;
        ctr_d   = CTR_W'(1);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[e] <= 1'b0;
        tag_q[e]   <= '0;
        ctr_q[e]   <= '0;
      end else begin
        valid_q[e] <= valid_d;
        tag_q[e]   <= tag_d;
        ctr_q[e]   <= ctr_d;
      end
    end

    AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (ctr_q[e] == $past(ctr_q[e]) || ctr_q[e] == '0 ||
                ctr_q[e] == CTR_W'(1) ||
                ctr_q[e] == CTR_W'($past(ctr_q[e]) + 1'b1))); // R7
  end

  logic [IDX_W-1:0] lk_idx;
  assign lk_idx = lk_pc[IDX_W-1:0];
  assign lk_sat = valid_q[lk_idx] && tag_q[lk_idx] == lk_pc[PCW-1:IDX_W] &&
                  ctr_q[lk_idx] == CTR_MAX;

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (valid_q == '0)); // R9
endmodule

// File: rtl/isp_predictor.sv
module isp_predictor
  import isp_pkg::*;
#(
  parameter int ADDR_W = XLEN,
  parameter int REGS   = NREG,
  parameter int ENT    = PRED_ENT,
  parameter int CW     = CONF_W,
  parameter int MSLOTS = MEM_SLOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ret_valid,
  input  logic [ADDR_W-1:0] ret_pc,
  input  logic [1:0]        ret_kind,
  input  logic [3:0]        ret_dst,
  input  logic [ADDR_W-1:0] ret_old,
  input  logic [ADDR_W-1:0] ret_new,
  input  logic              ret_br_ok,
  input  logic              ret_rs1_en,
  input  logic [3:0]        ret_rs1,
  input  logic              ret_rs2_en,
  input  logic [3:0]        ret_rs2,
  input  logic              ret_load,
  input  logic [ADDR_W-1:0] ret_addr,
  input  logic              rs_mismatch,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_skip,
  output logic              lead_recover
);
  localparam int PCW   = ADDR_W - 2;
  localparam int RIDX  = $clog2(REGS);
  localparam int RKEY  = RIDX + 1;

  ret_kind_e kind;
  logic      is_wr, silent, is_br, reg_wr, st_wr;
  logic [PCW-1:0] word_pc;

  assign kind    = ret_kind_e'(ret_kind);
  assign is_br   = ret_valid && kind == KIND_BRANCH;
  assign reg_wr  = ret_valid && kind == KIND_REGWR;
  assign st_wr   = ret_valid && kind == KIND_STORE;
  assign is_wr   = reg_wr || st_wr;
  assign silent  = ret_old == ret_new;
  assign word_pc = ret_pc[ADDR_W-1:2];

  // register pending-writer tracking
  logic             r_rd_en   [2];
  logic [RKEY-1:0]  r_rd_key  [2];
  logic             r_kill_v  [2];
  logic [PCW-1:0]   r_kill_pc [2];
  logic             r_dead_v;
  logic [PCW-1:0]   r_dead_pc;

  assign r_rd_en[0]  = ret_valid && ret_rs1_en;
  assign r_rd_en[1]  = ret_valid && ret_rs2_en;
  assign r_rd_key[0] = {1'b0, ret_rs1[RIDX-1:0]};
  assign r_rd_key[1] = {1'b0, ret_rs2[RIDX-1:0]};

  isp_write_tracker #(.SLOTS(REGS), .KEY_W(RKEY), .NRD(2), .PCW(PCW)) reg_trk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (rs_mismatch),
    .rd_en   (r_rd_en),
    .rd_key  (r_rd_key),
    .wr_en   (reg_wr),
    .wr_key  ({1'b0, ret_dst[RIDX-1:0]}),
    .wr_pc   (word_pc),
    .kill_v  (r_kill_v),
    .kill_pc (r_kill_pc),
    .dead_v  (r_dead_v),
    .dead_pc (r_dead_pc)
  );

  // memory-word pending-writer tracking
  logic             m_rd_en   [1];
  logic [PCW-1:0]   m_rd_key  [1];
  logic             m_kill_v  [1];
  logic [PCW-1:0]   m_kill_pc [1];
  logic             m_dead_v;
  logic [PCW-1:0]   m_dead_pc;

  assign m_rd_en[0]  = reg_wr && ret_load;
  assign m_rd_key[0] = ret_addr[ADDR_W-1:2];

  isp_write_tracker #(.SLOTS(MSLOTS), .KEY_W(PCW), .NRD(1), .PCW(PCW)) mem_trk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (rs_mismatch),
    .rd_en   (m_rd_en),
    .rd_key  (m_rd_key),
    .wr_en   (st_wr),
    .wr_key  (ret_addr[ADDR_W-1:2]),
    .wr_pc   (word_pc),
    .kill_v  (m_kill_v),
    .kill_pc (m_kill_pc),
    .dead_v  (m_dead_v),
    .dead_pc (m_dead_pc)
  );

  // evidence ports into the confidence table
  logic           up_v   [NUPD];
  logic           up_inc [NUPD];
  logic [PCW-1:0] up_pc  [NUPD];

  always_comb begin
    up_v[UP_SELF]   = is_br || (is_wr && silent);
    up_inc[UP_SELF] = is_br ? ret_br_ok : 1'b1;
    up_pc[UP_SELF]  = word_pc;
    up_v[UP_RKILL0] = r_kill_v[0]; up_inc[UP_RKILL0] = 1'b0; up_pc[UP_RKILL0] = r_kill_pc[0];
    up_v[UP_RKILL1] = r_kill_v[1]; up_inc[UP_RKILL1] = 1'b0; up_pc[UP_RKILL1] = r_kill_pc[1];
    up_v[UP_RDEAD]  = r_dead_v;    up_inc[UP_RDEAD]  = 1'b1; up_pc[UP_RDEAD]  = r_dead_pc;
    up_v[UP_MKILL]  = m_kill_v[0]; up_inc[UP_MKILL]  = 1'b0; up_pc[UP_MKILL]  = m_kill_pc[0];
    up_v[UP_MDEAD]  = m_dead_v;    up_inc[UP_MDEAD]  = 1'b1; up_pc[UP_MDEAD]  = m_dead_pc;
  end

  logic lk_sat;

  isp_conf_table #(.ENTRIES(ENT), .PCW(PCW), .CTR_W(CW), .NUP(NUPD)) table_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (rs_mismatch),
    .up_v   (up_v),
    .up_inc (up_inc),
    .up_pc  (up_pc),
    .lk_pc  (lk_pc[ADDR_W-1:2]),
    .lk_sat (lk_sat)
  );

  logic skip_d, rec_d;
  assign skip_d = lk_valid && lk_sat && !rs_mismatch;
  assign rec_d  = rs_mismatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_skip      <= 1'b0;
      lead_recover <= 1'b0;
    end else begin
      lk_skip      <= skip_d;
      lead_recover <= rec_d;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{ret_pc[1:0], ret_addr[1:0], lk_pc[1:0], ret_dst, ret_rs1, ret_rs2};

  AST_SKIP_OFF_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rs_mismatch |=> !lk_skip); // R9
  AST_RECOVER_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rs_mismatch |=> lead_recover); // R10
  AST_RECOVER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_mismatch |=> !lead_recover); // R10
  AST_SKIP_NEEDS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    lk_skip |-> $past(lk_valid)); // R2
endmodule

// File: tb/isp_predictor_tb.sv
`timescale 1ns/1ps
module isp_predictor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ret_valid, ret_br_ok, ret_rs1_en, ret_rs2_en, ret_load;
  logic [31:0] ret_pc, ret_old, ret_new, ret_addr, lk_pc;
  logic [1:0]  ret_kind;
  logic [3:0]  ret_dst, ret_rs1, ret_rs2;
  logic        rs_mismatch, lk_valid;
  logic        lk_skip, lead_recover;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  isp_predictor dut_i (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_pc(ret_pc),
    .ret_kind(ret_kind), .ret_dst(ret_dst), .ret_old(ret_old), .ret_new(ret_new),
    .ret_br_ok(ret_br_ok), .ret_rs1_en(ret_rs1_en), .ret_rs1(ret_rs1),
    .ret_rs2_en(ret_rs2_en), .ret_rs2(ret_rs2), .ret_load(ret_load),
    .ret_addr(ret_addr), .rs_mismatch(rs_mismatch), .lk_valid(lk_valid),
    .lk_pc(lk_pc), .lk_skip(lk_skip), .lead_recover(lead_recover)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic [15:0] pc;
    logic [3:0]  dst;
    logic        sil;
    logic        bok;
    logic        rde;
    logic [3:0]  rs;
    logic        ld;
    logic [11:0] addr;
    logic [15:0] chk;
    logic        exp;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VECS [NV] = '{
    // R3: correct branch at 0x100, skip only once count reaches 7, saturates
    '{2'd3,16'h0100,4'd0,1'b0,1'b1,1'b0,4'd0,1'b0,12'h000,16'h0100,1'b0},
    '{2'd3,16'h0100,4'd0,1'b0,1'b1,1'b0,4'd0,1'b0,12'h000,16'h0100,1'b0},
    '{2'd3,16'h0100,4'd0,1'b0,1'b1,1'b0,4'd0,1'b0,12'h000,16'h0100,1'b0},
    '{2'd3,16'h0100,4'd0,1'b0,1'b1,1'b0,4'd0,1'b0,12'h000,16'h0100,1'b0},
    '{2'd3,16'h0100,4'd0,1'b0,1'b1,1'b0,4'd0,1'b0,12'h000,16'h0100,1'b0},
    '{2'd3,16'h0100,4'd0,1'b0,1'b1,1'b0,4'd0,1'b0,12'h000,16'h0100,1'b0},
    '{2'd3,16'h0100,4'd0,1'b0,1'b1,1'b0,4'd0,1'b0,12'h000,16'h0100,1'b1},
    '{2'd3,16'h0100,4'd0,1'b0,1'b1,1'b0,4'd0,1'b0,12'h000,16'h0100,1'b1},
    '{2'd3,16'h0100,4'd0,1'b0,1'b0,1'b0,4'd0,1'b0,12'h000,16'h0100,1'b0},
    // R4 R7: silent writes to r3 at 0x204, silent and dead evidence share one step
    '{2'd1,16'h0204,4'd3,1'b1,1'b0,1'b0,4'd0,1'b0,12'h000,16'h0204,1'b0},
    '{2'd1,16'h0204,4'd3,1'b1,1'b0,1'b0,4'd0,1'b0,12'h000,16'h0204,1'b0},
    '{2'd1,16'h0204,4'd3,1'b1,1'b0,1'b0,4'd0,1'b0,12'h000,16'h0204,1'b0},
    '{2'd1,16'h0204,4'd3,1'b1,1'b0,1'b0,4'd0,1'b0,12'h000,16'h0204,1'b0},
    '{2'd1,16'h0204,4'd3,1'b1,1'b0,1'b0,4'd0,1'b0,12'h000,16'h0204,1'b0},
    '{2'd1,16'h0204,4'd3,1'b1,1'b0,1'b0,4'd0,1'b0,12'h000,16'h0204,1'b0},
    '{2'd1,16'h0204,4'd3,1'b1,1'b0,1'b0,4'd0,1'b0,12'h000,16'h0204,1'b1},
    // R5: value-changing writes to r5 at 0x308 count only when overwritten
    '{2'd1,16'h0308,4'd5,1'b0,1'b0,1'b0,4'd0,1'b0,12'h000,16'h0308,1'b0},
    '{2'd1,16'h0308,4'd5,1'b0,1'b0,1'b0,4'd0,1'b0,12'h000,16'h0308,1'b0},
    '{2'd1,16'h0308,4'd5,1'b0,1'b0,1'b0,4'd0,1'b0,12'h000,16'h0308,1'b0},
    '{2'd1,16'h0308,4'd5,1'b0,1'b0,1'b0,4'd0,1'b0,12'h000,16'h0308,1'b0},
    '{2'd1,16'h0308,4'd5,1'b0,1'b0,1'b0,4'd0,1'b0,12'h000,16'h0308,1'b0},
    '{2'd1,16'h0308,4'd5,1'b0,1'b0,1'b0,4'd0,1'b0,12'h000,16'h0308,1'b0},
    '{2'd1,16'h0308,4'd5,1'b0,1'b0,1'b0,4'd0,1'b0,12'h000,16'h0308,1'b0},
    '{2'd1,16'h0308,4'd5,1'b0,1'b0,1'b0,4'd0,1'b0,12'h000,16'h0308,1'b1},
    // R6: read of r5 resets the writer at 0x308
    '{2'd0,16'h0410,4'd0,1'b0,1'b0,1'b1,4'd5,1'b0,12'h000,16'h0308,1'b0},
    // R5: stores to word 0x040 at 0x514
    '{2'd2,16'h0514,4'd0,1'b0,1'b0,1'b0,4'd0,1'b0,12'h040,16'h0514,1'b0},
    '{2'd2,16'h0514,4'd0,1'b0,1'b0,1'b0,4'd0,1'b0,12'h040,16'h0514,1'b0},
    '{2'd2,16'h0514,4'd0,1'b0,1'b0,1'b0,4'd0,1'b0,12'h040,16'h0514,1'b0},
    '{2'd2,16'h0514,4'd0,1'b0,1'b0,1'b0,4'd0,1'b0,12'h040,16'h0514,1'b0},
    '{2'd2,16'h0514,4'd0,1'b0,1'b0,1'b0,4'd0,1'b0,12'h040,16'h0514,1'b0},
    '{2'd2,16'h0514,4'd0,1'b0,1'b0,1'b0,4'd0,1'b0,12'h040,16'h0514,1'b0},
    '{2'd2,16'h0514,4'd0,1'b0,1'b0,1'b0,4'd0,1'b0,12'h040,16'h0514,1'b0},
    '{2'd2,16'h0514,4'd0,1'b0,1'b0,1'b0,4'd0,1'b0,12'h040,16'h0514,1'b1},
    // R6: load of word 0x040 resets the store at 0x514
    '{2'd1,16'h061C,4'd9,1'b0,1'b0,1'b0,4'd0,1'b1,12'h040,16'h0514,1'b0}
  };

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic idle_ret();
    ret_valid = 1'b0; ret_kind = 2'd0; ret_pc = '0; ret_dst = '0;
    ret_old = '0; ret_new = '0; ret_br_ok = 1'b0; ret_rs1_en = 1'b0;
    ret_rs1 = '0; ret_rs2_en = 1'b0; ret_rs2 = '0; ret_load = 1'b0; ret_addr = '0;
  endtask

  task automatic drive_vec(input vec_t v, input int n);
    ret_valid = 1'b1; ret_kind = v.kind; ret_pc = {16'h0, v.pc}; ret_dst = v.dst;
    ret_old = '0; ret_new = v.sil ? 32'd0 : 32'(n + 1); ret_br_ok = v.bok;
    ret_rs1_en = v.rde; ret_rs1 = v.rs; ret_load = v.ld; ret_addr = {20'h0, v.addr};
  endtask

  task automatic branch_at(input logic [31:0] pc, input logic ok);
    idle_ret();
    ret_valid = 1'b1; ret_kind = 2'd3; ret_pc = pc; ret_br_ok = ok;
  endtask

  // lookup driven now, answer read one falling edge later
  task automatic lookup(input logic [31:0] pc, output logic ans);
    @(negedge clk);
    idle_ret();
    lk_valid = 1'b1; lk_pc = pc;
    @(negedge clk);
    ans = lk_skip;
    lk_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic ans;
    rst_n = 1'b0; rs_mismatch = 1'b0; lk_valid = 1'b0; lk_pc = '0;
    idle_ret();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(lk_skip, 1'b0, "R1 skip after reset");
    check(lead_recover, 1'b0, "R1 recover after reset");
    lookup(32'h0100, ans);
    check(ans, 1'b0, "R1 empty table");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive_vec(VECS[i], i);
      lookup({16'h0, VECS[i].chk}, ans);
      check(ans, VECS[i].exp, $sformatf("vector %0d (R3/R4/R5/R6/R7)", i));
    end

    // R2: no answer without a valid lookup
    @(negedge clk);
    idle_ret();
    lk_valid = 1'b0; lk_pc = 32'h0204;
    @(negedge clk);
    check(lk_skip, 1'b0, "R2 lookup not valid");

    // R8: alias 0x104 shares index with 0x204
    lookup(32'h0104, ans);
    check(ans, 1'b0, "R8 alias tag mismatch");
    lookup(32'h0204, ans);
    check(ans, 1'b1, "R8 owner still saturated");
    @(negedge clk);
    branch_at(32'h0104, 1'b1);
    lookup(32'h0204, ans);
    check(ans, 1'b0, "R8 entry replaced");

    // R11: count at 0x100 is 0; six correct, then retire with lookup together
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      branch_at(32'h0100, 1'b1);
    end
    @(negedge clk);
    branch_at(32'h0100, 1'b1);
    lk_valid = 1'b1; lk_pc = 32'h0100;
    @(negedge clk);
    idle_ret();
    lk_valid = 1'b0;
    check(lk_skip, 1'b0, "R11 pre-update answer");
    lookup(32'h0100, ans);
    check(ans, 1'b1, "R11 post-update answer");

    // R9 R10: clear while skip is high, with a retire in the same cycle
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = 32'h0100;
    @(negedge clk);
    check(lk_skip, 1'b1, "R9 skip high before clear");
    rs_mismatch = 1'b1;
    branch_at(32'h0100, 1'b1);
    @(negedge clk);
    rs_mismatch = 1'b0;
    idle_ret();
    check(lk_skip, 1'b0, "R9 skip low after clear");
    check(lead_recover, 1'b1, "R10 recover pulse");
    @(negedge clk);
    lk_valid = 1'b0;
    check(lead_recover, 1'b0, "R10 recover single cycle");
    check(lk_skip, 1'b0, "R9 cleared counter");
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      branch_at(32'h0100, 1'b1);
    end
    lookup(32'h0100, ans);
    check(ans, 1'b0, "R9 retire during clear ignored");
    @(negedge clk);
    branch_at(32'h0100, 1'b1);
    lookup(32'h0100, ans);
    check(ans, 1'b1, "R9 relearn after clear");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule